// File: doc/BRIEF.md
# ATA Taskfile Command Issue Sequencer

This block sits on the host side of a parallel ATA port and turns one command request into an ordered string of single-byte register transactions. On a start pulse it latches the command fields: command byte, drive select, 16-bit feature value, 16-bit sector count, 48-bit LBA and a flag that picks 28-bit or 48-bit addressing. It then presents one transaction at a time on a request port and moves to the next one only after the attached bus agent acknowledges it.

The same engine also has a read-back operation that returns a 48-bit LBA reported by the drive. It reads the three LBA registers once to get the low half. It then sets the high-order-byte select bit in device control and reads the three registers again to get the upper half. It does not clear that bit afterwards, because the register writes of the next command clear it inside the drive. Status polling, data transfers and bus timing belong to other blocks.

Top module: `ata_tf_sequencer`

## Requirements
- R1: During reset and after it, `busy_o`, `done_o` and `req_o` are low and `lba_rd_o` is zero.
- R2: A 48-bit command issues 12 writes in this order: feature[15:8], feature[7:0], count[15:8], count[7:0], LBA[31:24] then LBA[7:0] to the LBA-low register, LBA[39:32] then LBA[15:8] to LBA-mid, LBA[47:40] then LBA[23:16] to LBA-high, then device, then command.
- R3: A 28-bit command issues 7 writes: feature[7:0], count[7:0], LBA[7:0], LBA[15:8], LBA[23:16], device, command. It writes no high bytes and ignores LBA bits 47:28.
- R4: The device byte has bit 6 set, bit 4 equal to the drive-select input and bits 7 and 5 clear. Its bits 3:0 carry LBA[27:24] in 28-bit mode and are zero in 48-bit mode.
- R5: The command byte is always the last write of a command.
- R6: Register indices on `req_reg_o` are fixed: 1 feature, 2 count, 3 LBA-low, 4 LBA-mid, 5 LBA-high, 6 device, 7 command, 8 device control.
- R7: While `req_o` is high and `ack_i` is low, the request and its index, direction and write byte stay unchanged.
- R8: Read-back issues reads of registers 3, 4 and 5, then a write of 0x80 to register 8, then reads of 3, 4 and 5 again. No read occurs during a command.
- R9: After read-back, `lba_rd_o` holds the first-pass bytes in bits 23:0 (low, mid, high) and the second-pass bytes in bits 47:24. A command leaves it unchanged.
- R10: `done_o` pulses for exactly one cycle, in the cycle after the final transaction is acknowledged. `busy_o` is low in that cycle.
- R11: A start pulse while busy is ignored, and inputs that change after a start has been accepted have no effect on that operation. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| rdback_i | input | 1 | 1 selects LBA read-back, 0 selects command issue |
| mode48_i | input | 1 | 1 selects 48-bit addressing |
| lba_i | input | 48 | Logical block address |
| count_i | input | 16 | Sector count |
| feat_i | input | 16 | Feature value |
| drv_i | input | 1 | Drive select |
| cmd_i | input | 8 | Command byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| req_o | output | 1 | Transaction request |
| req_we_o | output | 1 | 1 write, 0 read |
| req_reg_o | output | 4 | Register index |
| req_wdata_o | output | 8 | Write byte |
| ack_i | input | 1 | Transaction acknowledge |
| rdata_i | input | 8 | Read byte, valid with `ack_i` on reads |
| lba_rd_o | output | 48 | Assembled read-back LBA |

## Verification
The assertions check every cycle that a pending transaction holds still until it is acknowledged (R7), that device bytes carry the addressing-mode bit (R4), that done is a lone pulse that follows the command write or the last read (R5, R10), and that reads occur only in read-back (R8). The complete ordering of bytes, the 28-bit and 48-bit mappings, the assembled LBA and the drive's high-byte select state can be shown only by the bench's scenarios. Those scenarios include irregular acknowledge delays, starts while busy, inputs changed mid-run and back-to-back operations.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int REG_W  = 4;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int HOB_BIT = 7;
  localparam int LBA_MODE_BIT = 6;
  localparam int DRV_BIT = 4;
  localparam int WR48_LAST = 11;
  localparam int RB_LAST   = 6;
  localparam int RB_CTRL   = 3;

  typedef enum logic [REG_W-1:0] {
    RG_NONE = 4'd0,
    RG_FEAT = 4'd1,
    RG_CNT  = 4'd2,
    RG_LO   = 4'd3,
    RG_MID  = 4'd4,
    RG_HI   = 4'd5,
    RG_DEV  = 4'd6,
    RG_CMD  = 4'd7,
    RG_DCTL = 4'd8
  } reg_e;

  typedef struct packed {
    logic              we;
    reg_e              rsel;
    logic [BYTE_W-1:0] wdata;
    logic              last;
  } step_t;
endpackage

// File: rtl/ata_tf_stepgen.sv
module ata_tf_stepgen
  import ata_tf_pkg::*;
#(
  parameter int LBA_W = 48,
  parameter int CNT_W = 16
) (
  input  logic             op_rd,
  input  logic             mode48,
  input  logic [LBA_W-1:0] lba,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] feat,
  input  logic             drv,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  logic [IDX_W-1:0]  widx;
  logic [BYTE_W-1:0] dev_b;

  always_comb begin
    widx = idx;
    if (!mode48) begin
      case (idx)
        4'd0:    widx = 4'd1;
        4'd1:    widx = 4'd3;
        4'd2:    widx = 4'd5;
        4'd3:    widx = 4'd7;
        4'd4:    widx = 4'd9;
        4'd5:    widx = 4'd10;
        default: widx = 4'd11;
      endcase
    end
  end

  always_comb begin
    dev_b = '0;
    dev_b[LBA_MODE_BIT] = 1'b1;
    dev_b[DRV_BIT]      = drv;
    if (!mode48) dev_b[3:0] = lba[27:24];
  end

  always_comb begin
    step = '0;
    if (op_rd) begin
      step.last = (idx == IDX_W'(RB_LAST));
      case (idx)
        4'd0, 4'd4: step.rsel = RG_LO;
        4'd1, 4'd5: step.rsel = RG_MID;
        4'd2, 4'd6: step.rsel = RG_HI;
        default: begin
          step.we   = 1'b1;
          step.rsel = RG_DCTL;
          step.wdata[HOB_BIT] = 1'b1;
        end
      endcase
    end else begin
      step.we   = 1'b1;
      step.last = (widx == IDX_W'(WR48_LAST));
      case (widx)
        4'd0:  begin step.rsel = RG_FEAT; step.wdata = feat[15:8]; end
        4'd1:  begin step.rsel = RG_FEAT; step.wdata = feat[7:0];  end
        4'd2:  begin step.rsel = RG_CNT;  step.wdata = cnt[15:8];  end
        4'd3:  begin step.rsel = RG_CNT;  step.wdata = cnt[7:0];   end
        4'd4:  begin step.rsel = RG_LO;   step.wdata = lba[31:24]; end
        4'd5:  begin step.rsel = RG_LO;   step.wdata = lba[7:0];   end
        4'd6:  begin step.rsel = RG_MID;  step.wdata = lba[39:32]; end
        4'd7:  begin step.rsel = RG_MID;  step.wdata = lba[15:8];  end
        4'd8:  begin step.rsel = RG_HI;   step.wdata = lba[47:40]; end
        4'd9:  begin step.rsel = RG_HI;   step.wdata = lba[23:16]; end
        4'd10: begin step.rsel = RG_DEV;  step.wdata = dev_b;      end
        default: begin step.rsel = RG_CMD; step.wdata = cmd;       end
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic             last_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e              state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_RUN;
          idx_d    = '0;
        end
      end
      default: begin
        if (ack_i) begin
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign idx_o  = idx_q;
  assign done_o = done_q;

  // R7: position in the sequence holds until acknowledged
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ack_i) |=> (busy_o && $stable(idx_o)));
  // R10: done is a single-cycle pulse while idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R11: a start while busy does not restart the sequence
  a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !ack_i) |=> $stable(idx_o));
endmodule

// File: rtl/ata_tf_rdback.sv
module ata_tf_rdback
  import ata_tf_pkg::*;
#(
  parameter int LBA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [LBA_W-1:0]  lba_o
);
  localparam int NBYTE = LBA_W / BYTE_W;
  localparam int HALF  = NBYTE / 2;

  for (genvar g = 0; g < NBYTE; g++) begin : g_slot
    localparam int SLOT = (g < HALF) ? g : g + 1;
    logic en;
    assign en = take_i && (idx_i == IDX_W'(SLOT));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lba_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (en) lba_o[g*BYTE_W +: BYTE_W] <= rdata_i;
    end
  end

  // R9: the high-select control slot never captures read data
  a_r9_no_ctrl_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (idx_i != IDX_W'(RB_CTRL)));
endmodule

// File: rtl/ata_tf_sequencer.sv
module ata_tf_sequencer
  import ata_tf_pkg::*;
#(
  parameter int LBA_W = 48,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rdback_i,
  input  logic              mode48_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  feat_i,
  input  logic              drv_i,
  input  logic [BYTE_W-1:0] cmd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_o,
  output logic              req_we_o,
  output logic [REG_W-1:0]  req_reg_o,
  output logic [BYTE_W-1:0] req_wdata_o,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [LBA_W-1:0]  lba_rd_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              accept, busy, take;
  logic [IDX_W-1:0]  idx;
  step_t             step;
  logic              cap_rd, cap_m48, cap_drv;
  logic [LBA_W-1:0]  cap_lba;
  logic [CNT_W-1:0]  cap_cnt, cap_feat;
  logic [BYTE_W-1:0] cap_cmd;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cap_rd <= 1'b0; cap_m48 <= 1'b0; cap_drv <= 1'b0;
      cap_lba <= '0; cap_cnt <= '0; cap_feat <= '0; cap_cmd <= '0;
    end else if (accept) begin
      cap_rd <= rdback_i; cap_m48 <= mode48_i; cap_drv <= drv_i;
      cap_lba <= lba_i; cap_cnt <= count_i; cap_feat <= feat_i; cap_cmd <= cmd_i;
    end
  end

  ata_tf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .ack_i(ack_i),
    .last_i(step.last), .busy_o(busy), .accept_o(accept), .idx_o(idx),
    .done_o(done_o)
  );

  ata_tf_stepgen #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_gen (
    .op_rd(cap_rd), .mode48(cap_m48), .lba(cap_lba), .cnt(cap_cnt),
    .feat(cap_feat), .drv(cap_drv), .cmd(cap_cmd), .idx(idx), .step(step)
  );

  assign take = busy && ack_i && !step.we;

  ata_tf_rdback #(.LBA_W(LBA_W)) u_rb (
    .clk(clk), .rst_n(rst_int_n), .take_i(take), .idx_i(idx),
    .rdata_i(rdata_i), .lba_o(lba_rd_o)
  );

  assign busy_o      = busy;
  assign req_o       = busy;
  assign req_we_o    = busy & step.we;
  assign req_reg_o   = busy ? step.rsel : RG_NONE;
  assign req_wdata_o = busy ? step.wdata : '0;

  // R7: a pending request stays unchanged until acknowledged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_o && !ack_i) |=> (req_o && $stable(req_we_o) && $stable(req_reg_o)
                           && $stable(req_wdata_o)));
  // R4: device writes carry the addressing-mode bit and reserved bits clear
  a_r4_dev_byte: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_o && req_we_o && req_reg_o == RG_DEV) |->
      (req_wdata_o[LBA_MODE_BIT] && !req_wdata_o[7] && !req_wdata_o[5]));
  // R5: a command finishes only with the command register write
  a_r5_cmd_last: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !cap_rd) |-> $past(ack_i && req_reg_o == RG_CMD));
  // R8: reads appear only during read-back
  a_r8_read_only_rb: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_o && !req_we_o) |-> cap_rd);
endmodule

// File: tb/tb_ata_tf_sequencer.sv
module tb_ata_tf_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i = 1'b0, rdback_i = 1'b0, mode48_i = 1'b0, drv_i = 1'b0;
  logic [47:0] lba_i = '0;
  logic [15:0] count_i = '0, feat_i = '0;
  logic [7:0]  cmd_i = '0;
  logic        busy_o, done_o, req_o, req_we_o;
  logic [3:0]  req_reg_o;
  logic [7:0]  req_wdata_o;
  logic        ack_i = 1'b0;
  logic [7:0]  rdata_i = '0;
  logic [47:0] lba_rd_o;

  always #2.5 clk = ~clk;

  ata_tf_sequencer dut (.*);

  int total = 0, bad = 0, cyc = 0;
  logic [12:0] q[$];
  logic        done_pend = 0, cur_rd = 0, hob = 0, fast = 1, held = 0;
  logic [47:0] lba_exp = '0, native = '0;
  logic [15:0] lfsr = 16'hACE1;
  string       cur_tag = "R2";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input bit we, input int rg, input logic [7:0] d);
    q.push_back({we, 4'(rg), d});
  endtask

  task automatic push_seq();
    if (rdback_i) begin
      cur_tag = "R8";
      push(0,3,0); push(0,4,0); push(0,5,0); push(1,8,8'h80);
      push(0,3,0); push(0,4,0); push(0,5,0);
    end else if (mode48_i) begin
      cur_tag = "R2";
      push(1,1,feat_i[15:8]); push(1,1,feat_i[7:0]);
      push(1,2,count_i[15:8]); push(1,2,count_i[7:0]);
      push(1,3,lba_i[31:24]); push(1,3,lba_i[7:0]);
      push(1,4,lba_i[39:32]); push(1,4,lba_i[15:8]);
      push(1,5,lba_i[47:40]); push(1,5,lba_i[23:16]);
      push(1,6,{1'b0,1'b1,1'b0,drv_i,4'h0}); push(1,7,cmd_i);
    end else begin
      cur_tag = "R3";
      push(1,1,feat_i[7:0]); push(1,2,count_i[7:0]);
      push(1,3,lba_i[7:0]); push(1,4,lba_i[15:8]); push(1,5,lba_i[23:16]);
      push(1,6,{1'b0,1'b1,1'b0,drv_i,lba_i[27:24]}); push(1,7,cmd_i);
    end
    cur_rd = rdback_i;
  endtask

  task automatic tick(input logic st);
    logic idle_pre, dn_e, ack;
    logic [12:0] fr;
    string tg;
    @(negedge clk);
    cyc++;
    dn_e = done_pend; done_pend = 0;
    chk(busy_o === (q.size() != 0), "R10 busy", busy_o, q.size() != 0);
    chk(done_o === dn_e, "R10 done", done_o, dn_e);
    if (dn_e) chk(lba_rd_o == lba_exp, "R9 lba_rd", lba_rd_o, lba_exp);
    if (q.size() != 0) begin
      fr = q[0];
      tg = held ? "R7" : cur_tag;
      chk(req_o === 1'b1, {tg, " req"}, req_o, 1);
      chk(req_we_o === fr[12], {tg, " dir"}, req_we_o, fr[12]);
      chk(req_reg_o === fr[11:8], {tg, " R6 index"}, req_reg_o, fr[11:8]);
      if (fr[12]) begin
        tg = (fr[11:8] == 6) ? "R4" : (fr[11:8] == 7) ? "R5" : tg;
        chk(req_wdata_o === fr[7:0], {tg, " wdata"}, req_wdata_o, fr[7:0]);
      end
    end else begin
      chk(req_o === 1'b0, "R11 idle req", req_o, 0);
    end
    idle_pre = (q.size() == 0);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ack = req_o && (fast || lfsr[1:0] != 2'b00);
    held = req_o && !ack;
    ack_i = ack;
    rdata_i = '0;
    if (ack && q.size() != 0) begin
      fr = q.pop_front();
      if (!fr[12]) begin
        case (fr[11:8])
          4'd3: rdata_i = hob ? native[31:24] : native[7:0];
          4'd4: rdata_i = hob ? native[39:32] : native[15:8];
          default: rdata_i = hob ? native[47:40] : native[23:16];
        endcase
      end else begin
        hob = (fr[11:8] == 4'd8) ? fr[7] : 1'b0;
      end
      if (q.size() == 0) begin
        done_pend = 1;
        if (cur_rd) lba_exp = native;
      end
    end
    start_i = st;
    if (st && idle_pre) push_seq();
  endtask

  task automatic run_op(input logic rb, input logic m48, input logic [47:0] l,
                        input logic [15:0] c, input logic [15:0] f,
                        input logic d, input logic [7:0] cm);
    rdback_i = rb; mode48_i = m48; lba_i = l; count_i = c; feat_i = f;
    drv_i = d; cmd_i = cm;
    tick(1);
    while (q.size() != 0 && cyc < 100000) tick(0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o === 0, "R1 busy", busy_o, 0);
    chk(req_o === 0, "R1 req", req_o, 0);
    chk(done_o === 0, "R1 done", done_o, 0);
    chk(lba_rd_o === '0, "R1 lba_rd", lba_rd_o, 0);
    rst_n = 1'b1;
    repeat (4) tick(0);

    // R2 48-bit command, immediate acknowledge
    run_op(0, 1, 48'hA1B2C3D4E5F6, 16'h1234, 16'h5678, 0, 8'h35);
    tick(0);
    // R3 R4 28-bit, drive 1, upper LBA bits must be dropped
    run_op(0, 0, 48'hFFFF_F9AB_CDEF, 16'h00AA, 16'hBB01, 1, 8'hC8);
    // R8 R9 read-back started in the done cycle (R11)
    native = 48'h0102_0304_0506;
    run_op(1, 0, '0, '0, '0, 0, 8'h00);
    tick(0); tick(0);
    // R9 a command leaves the read-back result unchanged; random acks (R7)
    fast = 0;
    run_op(0, 1, 48'h0000_0FED_CBA9, 16'hFFFF, 16'h0001, 1, 8'h24);
    // R11 start while busy and input changes after acceptance are ignored
    rdback_i = 0; mode48_i = 0; lba_i = 48'h1111_2222_3333; count_i = 16'h0102;
    feat_i = 16'h0304; drv_i = 0; cmd_i = 8'h20;
    tick(1);
    tick(0); tick(0);
    rdback_i = 1; mode48_i = 1; lba_i = 48'h9999_8888_7777; cmd_i = 8'hEE;
    tick(1); tick(1);
    while (q.size() != 0 && cyc < 100000) tick(0);
    tick(0);
    // R8 R9 second read-back under random acks, different value
    native = 48'hFEDC_BA98_7654;
    run_op(1, 1, '0, '0, '0, 1, 8'h00);
    tick(0);
    // R2 48-bit after read-back, high-select must be cleared by writes
    run_op(0, 1, 48'h8000_0000_0001, 16'h0000, 16'h0000, 0, 8'h25);
    repeat (3) tick(0);
    if (cyc >= 100000) chk(0, "watchdog", cyc, 100000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    chk(0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule